// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block walks a DDR3 memory through its power-up procedure after a start request. It first holds the device in reset with clock enable low while every rank is selected, releases reset, and then raises clock enable. It then visits each populated rank in turn. For each rank that is not excluded it issues the four mode-register loads and a long ZQ calibration, leaving the required idle gap after each command. Each wait is a parameter, so the same RTL serves silicon timing (hundreds of microseconds) and short simulation runs. A skip-delays input also collapses every wait to a single cycle.

The rank count, the skip mask, the mirroring mask and the skip-delays input are all captured when the sequence starts. Downstream logic turns the command code into pin activity. `done_o` stays high until a later start reruns the whole procedure.

Top module: `ddr3_init_seq`

## Requirements
- R1: After reset, and until the first start: reset_n_o=0, cke_o=0, cs_n_o all ones, cmd_valid_o=0, cmd_o=0, mem_stable_o=0, done_o=0.
- R2: Starting on the clock edge that samples start_i high, reset_n_o=0, cke_o=0 and cs_n_o all zeros (all ranks selected) hold for exactly T_INIT cycles.
- R3: mem_stable_o rises in the same cycle as reset_n_o. It stays high until the next accepted start, which clears it.
- R4: After the first wait, reset_n_o=1 with cke_o=0 for T_RST cycles. Then cke_o=1 for T_CKE cycles with cs_n_o still all zeros. The first command follows one rank-selection cycle later.
- R5: For each visited rank r, commands appear in this order: MR2 (code 1), MR3 (code 2), MR1 (code 3), MR0 with DLL reset (code 4), then ZQCL (code 5). The code is in cmd_o[2:0]. Each command has cmd_valid_o high for one cycle, and cs_n_o has only bit r low while that rank is being served.
- R6: After each mode-register command, T_MRD idle cycles follow before the next command. After ZQCL, T_ZQ idle cycles follow before the sequencer moves on.
- R7: cmd_o[3] is 1 on the four mode-register commands of a rank whose mirror_i bit is set. It is 0 on ZQCL and on every command of a non-mirrored rank.
- R8: A rank whose skip_rank_i bit is set, or whose index is at least rank_cnt_i, receives no command. Each skipped rank index below NUM_RANKS costs one cycle with cs_n_o all ones.
- R9: When skip_delays_i is high at start, every wait (T_INIT, T_RST, T_CKE, T_MRD, T_ZQ) lasts exactly one cycle.
- R10: done_o rises one cycle after the rank search passes the last rank and stays high. A start during a running sequence is ignored. Configuration inputs changed after the start edge have no effect on that run.
- R11: cmd_o is 0 in every cycle in which cmd_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the power-up sequence (accepted when idle or done) |
| rank_cnt_i | input | $clog2(NUM_RANKS+1) | Number of populated ranks |
| skip_rank_i | input | NUM_RANKS | Per-rank exclusion mask |
| mirror_i | input | NUM_RANKS | Per-rank address-mirroring mask |
| skip_delays_i | input | 1 | Collapse all waits to one cycle |
| reset_n_o | output | 1 | Memory reset, active low |
| cke_o | output | 1 | Memory clock enable |
| cs_n_o | output | NUM_RANKS | Active-low chip-select mask, one bit per rank |
| cmd_o | output | 4 | Command request: [3] mirrored, [2:0] command code |
| cmd_valid_o | output | 1 | One-cycle strobe qualifying cmd_o |
| mem_stable_o | output | 1 | Memory clock/power declared stable |
| done_o | output | 1 | Sequence complete |

## Verification
The embedded assertions check properties that hold on every cycle. Clock enable is never high while reset is asserted, and the stable flag follows reset release. Each command strobe lasts one cycle and addresses exactly one rank, the code is zero between strobes, broadcast phases drive every select low, and the wait counter counts down steadily. Only the bench scenarios can show the exact length of each phase, the order of the command codes, the mirror flag for each rank, and which ranks are skipped. They also show the one-cycle collapse of the waits, the capture of configuration at start, and the rejection of a start in mid-sequence. The bench sweeps every skip mask against every rank count, with varied mirroring masks, and checks a cycle-by-cycle schedule computed arithmetically.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MR2  = 3'd1,
    OP_MR3  = 3'd2,
    OP_MR1  = 3'd3,
    OP_MR0  = 3'd4,
    OP_ZQCL = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_RST, ST_CKE, ST_NEXT, ST_CMD, ST_GAP, ST_DONE
  } st_e;

  // step 0..4 within a rank -> opcode
  function automatic op_e step_op(input logic [2:0] step);
    case (step)
      3'd0:    return OP_MR2;
      3'd1:    return OP_MR3;
      3'd2:    return OP_MR1;
      3'd3:    return OP_MR0;
      3'd4:    return OP_ZQCL;
      default: return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ddr3_init_cs_dec.sv
module ddr3_init_cs_dec #(
  parameter int NR = 4,
  parameter int RW = 3
) (
  input  logic          bcast_i,
  input  logic          sel_i,
  input  logic [RW-1:0] rank_i,
  output logic [NR-1:0] cs_n_o
);
  for (genvar i = 0; i < NR; i++) begin : g_cs
    assign cs_n_o[i] = bcast_i ? 1'b0 : !(sel_i && (rank_i == RW'(i)));
  end

  always_comb begin
    assert_bcast_all_R2: assert (!bcast_i || cs_n_o == '0);
  end
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int T_INIT    = 54000,
  parameter int T_RST     = 134000,
  parameter int T_CKE     = 250,
  parameter int T_MRD     = 4,
  parameter int T_ZQ      = 512,
  localparam int RW       = $clog2(NUM_RANKS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [RW-1:0]        rank_cnt_i,
  input  logic [NUM_RANKS-1:0] skip_rank_i,
  input  logic [NUM_RANKS-1:0] mirror_i,
  input  logic                 skip_delays_i,
  output logic                 reset_n_o,
  output logic                 cke_o,
  output logic [NUM_RANKS-1:0] cs_n_o,
  output logic [3:0]           cmd_o,
  output logic                 cmd_valid_o,
  output logic                 mem_stable_o,
  output logic                 done_o
);
  localparam int T_A   = (T_INIT > T_RST) ? T_INIT : T_RST;
  localparam int T_B   = (T_CKE > T_ZQ) ? T_CKE : T_ZQ;
  localparam int T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_C > T_MRD) ? T_C : T_MRD;
  localparam int CW    = $clog2(T_MAX + 1);

  st_e                  st_q, st_d;
  logic [RW-1:0]        rank_q, rank_d, cnt_q;
  logic [2:0]           step_q, step_d;
  logic [NUM_RANKS-1:0] skip_q, mir_q, skip_sh, mir_sh;
  logic                 fast_q, stable_q, stable_d;
  logic                 idle_like, accept, fast_eff;
  logic                 load, zero;
  logic [CW-1:0]        load_val;
  logic                 bcast, sel;
  op_e                  op;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign accept    = idle_like && start_i;
  assign fast_eff  = idle_like ? skip_delays_i : fast_q;
  assign skip_sh   = skip_q >> rank_q;
  assign mir_sh    = mir_q >> rank_q;
  assign op        = step_op(step_q);

  function automatic logic [CW-1:0] dly(input int t, input logic fast);
    return fast ? '0 : CW'(t - 1);
  endfunction

  always_comb begin
    st_d     = st_q;
    rank_d   = rank_q;
    step_d   = step_q;
    load     = 1'b0;
    load_val = '0;
    stable_d = stable_q;
    case (st_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        st_d     = ST_INIT;
        load     = 1'b1;
        load_val = dly(T_INIT, fast_eff);
        stable_d = 1'b0;
      end
      ST_INIT: if (zero) begin
        st_d     = ST_RST;
        load     = 1'b1;
        load_val = dly(T_RST, fast_eff);
        stable_d = 1'b1;
      end
      ST_RST: if (zero) begin
        st_d     = ST_CKE;
        load     = 1'b1;
        load_val = dly(T_CKE, fast_eff);
      end
      ST_CKE: if (zero) begin
        st_d   = ST_NEXT;
        rank_d = '0;
      end
      ST_NEXT: begin
        if (rank_q >= cnt_q || rank_q >= RW'(NUM_RANKS)) st_d = ST_DONE;
        else if (skip_sh[0]) rank_d = rank_q + 1'b1;
        else begin
          st_d   = ST_CMD;
          step_d = '0;
        end
      end
      ST_CMD: begin
        st_d     = ST_GAP;
        load     = 1'b1;
        load_val = (op == OP_ZQCL) ? dly(T_ZQ, fast_eff) : dly(T_MRD, fast_eff);
      end
      ST_GAP: if (zero) begin
        if (op == OP_ZQCL) begin
          st_d   = ST_NEXT;
          rank_d = rank_q + 1'b1;
        end else begin
          st_d   = ST_CMD;
          step_d = step_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rank_q   <= '0;
      step_q   <= '0;
      cnt_q    <= '0;
      skip_q   <= '0;
      mir_q    <= '0;
      fast_q   <= 1'b0;
      stable_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rank_q   <= rank_d;
      step_q   <= step_d;
      stable_q <= stable_d;
      if (accept) begin
        cnt_q  <= rank_cnt_i;
        skip_q <= skip_rank_i;
        mir_q  <= mirror_i;
        fast_q <= skip_delays_i;
      end
    end
  end

  ddr3_init_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  assign bcast = (st_q == ST_INIT) || (st_q == ST_RST) || (st_q == ST_CKE);
  assign sel   = (st_q == ST_CMD) || (st_q == ST_GAP);

  ddr3_init_cs_dec #(.NR(NUM_RANKS), .RW(RW)) u_cs (
    .bcast_i (bcast),
    .sel_i   (sel),
    .rank_i  (rank_q),
    .cs_n_o  (cs_n_o)
  );

  assign reset_n_o    = !((st_q == ST_IDLE) || (st_q == ST_INIT));
  assign cke_o        = reset_n_o && (st_q != ST_RST);
  assign cmd_valid_o  = (st_q == ST_CMD);
  assign cmd_o        = cmd_valid_o ? {(op != OP_ZQCL) && mir_sh[0], op} : 4'd0;
  assign mem_stable_o = stable_q;
  assign done_o       = (st_q == ST_DONE);

  assert_cke_after_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |-> reset_n_o);
  assert_stable_with_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_n_o |-> mem_stable_o);
  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  assert_one_rank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> ($countones(~cs_n_o) == 1));
  assert_cmd_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_o |-> (cmd_o == 4'd0));
  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cmd_valid_o && cke_o && reset_n_o));
endmodule

// File: tb/ddr3_init_seq_bench.sv
module ddr3_init_seq_bench;
  localparam int NR = 4;
  localparam int RW = $clog2(NR + 1);
  localparam int TI = 20, TR = 30, TC = 10, TM = 4, TZ = 16;
  localparam int LEN = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [RW-1:0] rank_cnt = '0;
  logic [NR-1:0] skip = '0, mir = '0;
  logic          fast = 1'b0;
  logic          reset_n, cke, cmd_valid, stable, done;
  logic [NR-1:0] cs_n;
  logic [3:0]    cmd;

  int n_checks = 0, n_fail = 0, cyc = 0;

  logic          e_rn [LEN];
  logic          e_cke[LEN];
  logic          e_stb[LEN];
  logic          e_v  [LEN];
  logic [3:0]    e_cmd[LEN];
  logic [NR-1:0] e_cs [LEN];
  int            e_done;

  always #10 clk = ~clk;

  ddr3_init_seq #(
    .NUM_RANKS(NR), .T_INIT(TI), .T_RST(TR), .T_CKE(TC), .T_MRD(TM), .T_ZQ(TZ)
  ) u_ddr3_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rank_cnt_i(rank_cnt),
    .skip_rank_i(skip), .mirror_i(mir), .skip_delays_i(fast),
    .reset_n_o(reset_n), .cke_o(cke), .cs_n_o(cs_n), .cmd_o(cmd),
    .cmd_valid_o(cmd_valid), .mem_stable_o(stable), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic put(input int k, input logic rn, input logic ck, input logic st,
                     input logic v, input logic [3:0] c, input logic [NR-1:0] cs);
    e_rn[k] = rn; e_cke[k] = ck; e_stb[k] = st; e_v[k] = v; e_cmd[k] = c; e_cs[k] = cs;
  endtask

  // expected schedule from the requirements; k=0 is the first cycle after the start edge
  task automatic build(input int cnt, input logic [NR-1:0] sk, input logic [NR-1:0] mr,
                       input logic f);
    int ti = f ? 1 : TI;
    int tr = f ? 1 : TR;
    int tc = f ? 1 : TC;
    int tm = f ? 1 : TM;
    int tz = f ? 1 : TZ;
    int t;
    int r = 0;
    for (int k = 0; k < LEN; k++) put(k, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '1);
    for (int k = 0; k < ti; k++) put(k, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, '0);
    for (int k = ti; k < ti + tr; k++) put(k, 1'b1, 1'b0, 1'b1, 1'b0, 4'd0, '0);
    for (int k = ti + tr; k < ti + tr + tc; k++) put(k, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, '0);
    t = ti + tr + tc;
    forever begin
      if (r >= cnt || r >= NR) begin
        e_done = t + 1;
        break;
      end
      if (sk[r]) begin
        t++; r++;
        continue;
      end
      t++;
      for (int j = 0; j < 5; j++) begin
        int g = (j == 4) ? tz : tm;
        logic [NR-1:0] one = ~(NR'(1) << r);
        put(t, 1'b1, 1'b1, 1'b1, 1'b1, {(j < 4) && mr[r], 3'(j + 1)}, one);
        for (int q = 1; q <= g; q++) put(t + q, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, one);
        t += 1 + g;
      end
      r++;
    end
  endtask

  task automatic run(input int cnt, input logic [NR-1:0] sk, input logic [NR-1:0] mr,
                     input logic f, input logic poke);
    string sfx = f ? " R9" : "";
    build(cnt, sk, mr, f);
    @(negedge clk);
    rank_cnt = RW'(cnt); skip = sk; mir = mr; fast = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble configuration after the start edge (R10: captured at start)
    rank_cnt = RW'(NR); skip = ~sk; mir = ~mr; fast = ~f;
    for (int k = 0; k <= e_done + 2; k++) begin
      string tp = (k < (f ? 1 : TI)) ? "R2" : "R4";
      chk(reset_n === e_rn[k], {tp, " reset_n", sfx}, reset_n, e_rn[k]);
      chk(cke === e_cke[k], {tp, " cke", sfx}, cke, e_cke[k]);
      chk(cs_n === e_cs[k], {"R5 cs_n", sfx}, cs_n, e_cs[k]);
      chk(stable === e_stb[k], {"R3 mem_stable", sfx}, stable, e_stb[k]);
      chk(cmd_valid === e_v[k], {"R6 cmd_valid timing", sfx}, cmd_valid, e_v[k]);
      if (e_v[k]) begin
        chk(cmd[2:0] === e_cmd[k][2:0], {"R5 command order", sfx}, cmd[2:0], e_cmd[k][2:0]);
        chk(cmd[3] === e_cmd[k][3], {"R7 mirror flag", sfx}, cmd[3], e_cmd[k][3]);
      end
      if (cmd_valid) begin
        int rr = -1;
        for (int i = 0; i < NR; i++) if (!cs_n[i]) rr = i;
        chk(rr >= 0 && rr < cnt && !sk[rr], "R8 command to excluded rank", rr, 0);
      end else begin
        chk(cmd === 4'd0, "R11 idle cmd", cmd, 0);
      end
      chk(done === (k >= e_done), "R10 done", done, k >= e_done);
      start = (poke && k == 3) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(reset_n === 1'b0, "R1 reset_n", reset_n, 0);
    chk(cke === 1'b0, "R1 cke", cke, 0);
    chk(cs_n === '1, "R1 cs_n", cs_n, '1);
    chk(cmd_valid === 1'b0 && cmd === 4'd0, "R1 cmd", cmd, 0);
    chk(stable === 1'b0 && done === 1'b0, "R1 flags", {stable, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(done === 1'b0 && reset_n === 1'b0, "R1 idle after reset", done, 0);

    run(NR, '0, 4'b1010, 1'b0, 1'b0);
    run(NR, 4'b0110, 4'b0011, 1'b0, 1'b1);
    for (int c = 0; c <= NR; c++)
      for (int s = 0; s < 16; s++)
        run(c, NR'(s), NR'(s ^ 5 ^ c), (s % 4) == 3, (s == 9));
    run(NR, '0, '1, 1'b1, 1'b1);
    run(0, '1, '0, 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule